// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

The unit operates on one selected bit of a byte operand. Each request carries the operand, a bit index from 0 to 7, an operation code and the current carry flag. Four operations work on the bit inside the byte: test, set, clear and invert. Two operations store the carry into the bit, either as it is or complemented. The remaining operations move the selected bit into the carry flag. They either load it, or combine it with the old carry by AND, OR or XOR, and each of these has a variant that uses the complemented bit.

Results are registered. One cycle after a request the unit presents four things: a response strobe; a write-back enable together with the new byte, for the operations that change the byte; and update enables for the zero flag and for the carry flag, each with its new value. A flag whose update enable is low must be left alone by the surrounding datapath. The unit does no addressing and no memory access. The caller fetches the operand and writes the byte back when the enable is high.

Top module: `bitop_unit`

## Requirements
- R1: While reset is applied and until the first request after reset, `rsp_valid`, `wb_en`, `z_we` and `c_we` are all low.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. With no request, no strobe or enable rises.
- R3: Code 0 (test) raises `z_we` with `z_out` = 1 when bit `req_idx` of `req_data` is 0, and 0 otherwise. It gives no write-back and no carry update.
- R4: Codes 1 (set), 2 (clear) and 3 (invert) raise `wb_en`. `wb_data` equals `req_data` with bit `req_idx` forced to 1, forced to 0, or flipped, respectively. No flag update enable rises.
- R5: Code 4 (load) raises `c_we` with `c_out` equal to bit `req_idx` of `req_data`. Code 5 (inverted load) gives its complement. Neither writes back.
- R6: Code 6 (store) raises `wb_en` with bit `req_idx` of `wb_data` equal to `c_in`. Code 7 (inverted store) writes the complement of `c_in`. Neither raises a flag update enable.
- R7: Codes 8/10/12 raise `c_we` with `c_out` equal to the selected bit ANDed/ORed/XORed with `c_in`. Codes 9/11/13 do the same using the complement of the selected bit. None writes back.
- R8: The bit acted on is the one at weight 1 shifted left by `req_idx`. In every write-back, all other bits of `wb_data` equal `req_data`.
- R9: Codes 14 and 15 are accepted (`rsp_valid` rises) but raise no `wb_en`, `z_we` or `c_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Operation code (0..13, see requirements) |
| req_idx | input | 3 | Index of the selected bit |
| req_data | input | 8 | Operand byte |
| c_in | input | 1 | Current carry flag |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| wb_en | output | 1 | Byte write-back enable |
| wb_data | output | 8 | Modified byte |
| z_we | output | 1 | Zero flag update enable |
| z_out | output | 1 | New zero flag |
| c_we | output | 1 | Carry flag update enable |
| c_out | output | 1 | New carry flag |

## Verification
On every cycle, the assertions check the following: the one-cycle request-to-response timing; the absence of strobes without a request; that at most one of the three update enables is high; that the test result matches the selected bit; that illegal codes cause no update; and that the bits outside the mask survive a write-back. The carry-logic truth tables only show up in the bench's scenarios, which sweep every code and index against the reference model with both carry values and several operand patterns. The same holds for the store variants and the exact byte produced by set, clear and invert.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [3:0] {
    K_NONE = 4'd0,
    K_TST  = 4'd1,
    K_SET  = 4'd2,
    K_CLR  = 4'd3,
    K_FLIP = 4'd4,
    K_LD   = 4'd5,
    K_ST   = 4'd6,
    K_AND  = 4'd7,
    K_OR   = 4'd8,
    K_XOR  = 4'd9
  } bit_kind_e;

  typedef struct packed {
    logic wb;
    logic zwe;
    logic cwe;
  } upd_t;

  localparam int unsigned OP_W    = 4;
  localparam int unsigned OP_LAST = 13;

endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  mask
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask[i] = (idx == IW'(i));
  end
endmodule

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output bit_kind_e       kind,
  output logic            inv,
  output upd_t            upd
);
  always_comb begin
    kind = K_NONE;
    inv  = op[0];
    upd  = '0;
    unique case (op)
      4'd0:  begin kind = K_TST;  inv = 1'b0; upd.zwe = 1'b1; end
      4'd1:  begin kind = K_SET;  inv = 1'b0; upd.wb  = 1'b1; end
      4'd2:  begin kind = K_CLR;  inv = 1'b0; upd.wb  = 1'b1; end
      4'd3:  begin kind = K_FLIP; inv = 1'b0; upd.wb  = 1'b1; end
      4'd4, 4'd5:   begin kind = K_LD;  upd.cwe = 1'b1; end
      4'd6, 4'd7:   begin kind = K_ST;  upd.wb  = 1'b1; end
      4'd8, 4'd9:   begin kind = K_AND; upd.cwe = 1'b1; end
      4'd10, 4'd11: begin kind = K_OR;  upd.cwe = 1'b1; end
      4'd12, 4'd13: begin kind = K_XOR; upd.cwe = 1'b1; end
      default: begin kind = K_NONE; inv = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  bit_kind_e    kind,
  input  logic         inv,
  input  logic [W-1:0] data,
  input  logic [W-1:0] mask,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         z_new,
  output logic         c_new
);
  logic sel_bit;
  logic opnd;
  logic cval;

  assign sel_bit = |(data & mask);
  assign opnd    = sel_bit ^ inv;
  assign cval    = c_in ^ inv;

  always_comb begin
    res   = data;
    z_new = 1'b0;
    c_new = c_in;
    unique case (kind)
      K_TST:  z_new = ~sel_bit;
      K_SET:  res = data | mask;
      K_CLR:  res = data & ~mask;
      K_FLIP: res = data ^ mask;
      K_ST:   res = cval ? (data | mask) : (data & ~mask);
      K_LD:   c_new = opnd;
      K_AND:  c_new = opnd & c_in;
      K_OR:   c_new = opnd | c_in;
      K_XOR:  c_new = opnd ^ c_in;
      default: ;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_op,
  input  logic [IW-1:0] req_idx,
  input  logic [W-1:0]  req_data,
  input  logic          c_in,
  output logic          rsp_valid,
  output logic          wb_en,
  output logic [W-1:0]  wb_data,
  output logic          z_we,
  output logic          z_out,
  output logic          c_we,
  output logic          c_out
);
  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // datapath
  logic [W-1:0] mask;
  bit_kind_e    kind;
  logic         inv;
  upd_t         upd;
  logic [W-1:0] alu_res;
  logic         alu_z;
  logic         alu_c;

  bitop_mask #(.W(W), .IW(IW)) u_mask (.idx(req_idx), .mask(mask));

  bitop_decode u_dec (.op(req_op), .kind(kind), .inv(inv), .upd(upd));

  bitop_alu #(.W(W)) u_alu (
    .kind(kind), .inv(inv), .data(req_data), .mask(mask), .c_in(c_in),
    .res(alu_res), .z_new(alu_z), .c_new(alu_c)
  );

  // next state
  logic         rsp_d, wb_d, zwe_d, cwe_d;
  logic [W-1:0] data_d;
  logic         z_d, c_d;
  logic         load_en;

  assign load_en = req_valid;

  always_comb begin
    rsp_d  = req_valid;
    wb_d   = req_valid & upd.wb;
    zwe_d  = req_valid & upd.zwe;
    cwe_d  = req_valid & upd.cwe;
    data_d = wb_data;
    z_d    = z_out;
    c_d    = c_out;
    if (load_en) begin
      data_d = alu_res;
      z_d    = alu_z;
      c_d    = alu_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid <= 1'b0;
      wb_en     <= 1'b0;
      z_we      <= 1'b0;
      c_we      <= 1'b0;
      wb_data   <= '0;
      z_out     <= 1'b0;
      c_out     <= 1'b0;
    end else begin
      rsp_valid <= rsp_d;
      wb_en     <= wb_d;
      z_we      <= zwe_d;
      c_we      <= cwe_d;
      wb_data   <= data_d;
      z_out     <= z_d;
      c_out     <= c_d;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> (!rsp_valid && !wb_en && !z_we && !c_we));

  // R4
  single_update_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({wb_en, z_we, c_we}));

  // R3
  test_result_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && req_op == 4'd0) |=>
      (z_we && !wb_en && !c_we && (z_out == ~$past(req_data[req_idx]))));

  // R9
  illegal_op_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && req_op > 4'(OP_LAST)) |=> (!wb_en && !z_we && !c_we));

  // R8
  always_ff @(posedge clk) begin
    if (rst_q && req_valid) begin
      keep_bits_chk: assert (((alu_res ^ req_data) & ~mask) == '0);
    end
  end
endmodule

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic [3:0]   req_op;
  logic [2:0]   req_idx;
  logic [W-1:0] req_data;
  logic         c_in;
  logic         rsp_valid, wb_en, z_we, z_out, c_we, c_out;
  logic [W-1:0] wb_data;

  int checks = 0;
  int fails  = 0;

  bitop_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_idx(req_idx), .req_data(req_data), .c_in(c_in),
    .rsp_valid(rsp_valid), .wb_en(wb_en), .wb_data(wb_data),
    .z_we(z_we), .z_out(z_out), .c_we(c_we), .c_out(c_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected results of the request in flight
  int e_rsp, e_wb, e_zwe, e_cwe, e_z, e_c, e_data, e_keep;
  string e_tag;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int v, input int op);
    if (!v) return "R2";
    if (op == 0) return "R3";
    if (op <= 3) return "R4";
    if (op <= 5) return "R5";
    if (op <= 7) return "R6";
    if (op <= 13) return "R7";
    return "R9";
  endfunction

  task automatic model(input int v, input int op, input int idx, input int d, input int c);
    int b, m;
    m = 1 << idx;
    b = (d >> idx) & 1;
    e_rsp = v; e_wb = 0; e_zwe = 0; e_cwe = 0; e_z = 0; e_c = 0;
    e_data = d; e_keep = d & ~m & 8'hFF;
    e_tag = tag_of(v, op);
    if (v) begin
      case (op)
        0:  begin e_zwe = 1; e_z = (b == 0); end
        1:  begin e_wb = 1; e_data = d | m; end
        2:  begin e_wb = 1; e_data = d & ~m & 8'hFF; end
        3:  begin e_wb = 1; e_data = d ^ m; end
        4:  begin e_cwe = 1; e_c = b; end
        5:  begin e_cwe = 1; e_c = 1 - b; end
        6:  begin e_wb = 1; e_data = c ? (d | m) : (d & ~m & 8'hFF); end
        7:  begin e_wb = 1; e_data = c ? (d & ~m & 8'hFF) : (d | m); end
        8:  begin e_cwe = 1; e_c = b & c; end
        9:  begin e_cwe = 1; e_c = (1 - b) & c; end
        10: begin e_cwe = 1; e_c = b | c; end
        11: begin e_cwe = 1; e_c = (1 - b) | c; end
        12: begin e_cwe = 1; e_c = b ^ c; end
        13: begin e_cwe = 1; e_c = (1 - b) ^ c; end
        default: ;
      endcase
    end
  endtask

  // called at a falling edge: drive, wait one cycle, compare
  task automatic step(input int v, input int op, input int idx, input int d, input int c);
    req_valid = 1'(v);
    req_op    = 4'(op);
    req_idx   = 3'(idx);
    req_data  = 8'(d);
    c_in      = 1'(c);
    model(v, op, idx, d, c);
    @(negedge clk);
    chk("R2", "rsp_valid", int'(rsp_valid), e_rsp);
    chk(e_tag, "wb_en", int'(wb_en), e_wb);
    chk(e_tag, "z_we", int'(z_we), e_zwe);
    chk(e_tag, "c_we", int'(c_we), e_cwe);
    if (e_wb != 0) begin
      chk(e_tag, "wb_data", int'(wb_data), e_data);
      chk("R8", "wb_data outside mask", int'(wb_data) & ~(1 << idx) & 8'hFF, e_keep);
    end
    if (e_zwe != 0) chk(e_tag, "z_out", int'(z_out), e_z);
    if (e_cwe != 0) chk(e_tag, "c_out", int'(c_out), e_c);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int pats[4];
    pats[0] = 8'hA5; pats[1] = 8'h5A; pats[2] = 8'h00; pats[3] = 8'hFF;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_idx = '0;
    req_data = '0; c_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    chk("R1", "strobes in reset", int'({rsp_valid, wb_en, z_we, c_we}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "strobes after reset", int'({rsp_valid, wb_en, z_we, c_we}), 0);

    // sweep of every code, index, pattern and carry value (R3..R9)
    for (int op = 0; op < 16; op++)
      for (int p = 0; p < 4; p++)
        for (int idx = 0; idx < 8; idx++)
          for (int c = 0; c < 2; c++)
            step(1, op, idx, pats[p], c);

    // idle gaps and back-to-back requests (R2)
    step(0, 1, 3, 8'h00, 0);
    step(1, 6, 7, 8'h00, 1);
    step(0, 6, 7, 8'h00, 1);
    step(0, 0, 0, 8'h00, 0);
    step(1, 0, 0, 8'h01, 0);
    step(1, 15, 2, 8'h04, 1);
    step(0, 2, 2, 8'hFF, 0);

    // pseudo-random mix of operand bytes
    for (int k = 0; k < 600; k++)
      step(($urandom % 5) != 0, $urandom % 16, $urandom % 8, $urandom % 256, $urandom % 2);

    step(0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule